// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

The block moves outgoing frames from memory to a byte stream without processor help. Software builds a ring of four-word descriptors in memory. Each descriptor names a buffer and a byte count, and software marks it as owned by hardware. Software then sets a poll bit. The engine walks the ring from its current position. For each owned descriptor it reads the length and the buffer address. It fetches the whole buffer into a local store and only then plays the bytes out on a valid/ready byte interface, marking the final byte. Afterwards it writes the first descriptor word back with the ownership bit cleared.

The ring closes through a wrap flag carried in the descriptor, not through a fixed count. A descriptor may also ask for a completion flag; that flag is cleared when software writes a one to it, and it drives an interrupt through an enable bit. When the engine meets a descriptor that software still owns, it clears the poll bit and waits. Memory is reached through a plain request/acknowledge word port, and a small register port holds the list base, the poll bit, the completion flag and the interrupt enable.

Top module: `txring_dma`

## Requirements
- R1: After reset the poll bit, completion flag, interrupt enable and list base read 0, and tx_tvalid_o, mem_req_o and irq_o are low.
- R2: A descriptor at byte address P is read as word 0 at P, then the length word at P+4, whose bits 31:16 give the byte count, then the buffer byte address at P+8. The word at P+12 is never read. A memory request holds its address and direction until it is acknowledged.
- R3: The buffer bytes are sent in address order, from any byte alignment, with little-endian lanes: byte address A is bits 8*(A mod 4)+7 down to 8*(A mod 4) of the word at A rounded down to a multiple of 4. tx_tlast_o is high on the final byte only.
- R4: No byte is presented on the stream while a memory request is open. The whole buffer is fetched before the first byte is offered.
- R5: While tx_tvalid_o is high and tx_tready_i is low, tx_tvalid_o, tx_tdata_o and tx_tlast_o hold their values.
- R6: After a descriptor is finished, its word 0 is written back with bit 31 (hardware owns) cleared and every other bit unchanged.
- R7: After a descriptor whose word 0 bit 30 (ring wrap) is set, the next descriptor is read from the list base. Otherwise it is read from the current address plus 16.
- R8: A descriptor whose bit 31 is clear is not sent and is not written. The engine clears the poll bit and stops there.
- R9: A descriptor that lacks either bit 29 (frame start) or bit 28 (frame end), or whose count is 0 or larger than MAXB, sends no bytes but is still handed back as in R6 and R7.
- R10: Finishing a descriptor whose bit 24 (completion request) is set raises the completion flag (register 2, bit 0). Writing 1 to that bit clears the flag, writing 0 has no effect, and a set arriving in the same cycle as a clear wins.
- R11: irq_o is high exactly when the completion flag and the interrupt enable (register 3, bit 0) are both 1.
- R12: A write to the list base (register 0, bits 3:0 forced to 0) while the engine is stopped moves the fetch position to that base. A later poll resumes from the position where the engine stopped.
- R13: Writing 1 to register 1 bit 0 sets the poll bit and starts the walk. Writing 0 has no effect. The bit reads 1 while the engine is walking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 base, 1 poll, 2 completion flag, 3 interrupt enable |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, same cycle |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access done; read data valid in this cycle |
| mem_rdata_i | input | 32 | Read data |
| tx_tvalid_o | output | 1 | Stream byte valid |
| tx_tready_i | input | 1 | Stream sink ready |
| tx_tdata_o | output | 8 | Stream byte |
| tx_tlast_o | output | 1 | Final byte of the frame |
| irq_o | output | 1 | Completion interrupt |

## Verification
A register write takes effect on the next clock edge, and reads return the same cycle. The completion flag rises on the edge that takes the acknowledge of the word-0 write-back, so irq_o follows in that same cycle. The stream starts one cycle after the acknowledge of the last buffer word, and each byte moves on the edge where valid and ready are both high. The bench therefore never counts cycles across a whole frame. It starts a walk and polls the poll bit until the engine has stopped, which can only happen after every write-back and after the read of the next descriptor. Only then does it compare the bytes captured so far, the descriptor words and the flag. Stream bytes are recorded on the falling edge, after ready is updated, so each record matches exactly the handshake taken at the following rising edge.

// File: rtl/txring_pkg.sv
package txring_pkg;
  // descriptor word 0 flag positions
  localparam int unsigned BIT_OWN  = 31;
  localparam int unsigned BIT_WRAP = 30;
  localparam int unsigned BIT_SOF  = 29;
  localparam int unsigned BIT_EOF  = 28;
  localparam int unsigned BIT_CMPL = 24;
  // register select codes
  localparam logic [1:0] RA_BASE = 2'd0;
  localparam logic [1:0] RA_POLL = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_IEN  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_W0, ST_W1, ST_W2, ST_BUF, ST_SEND, ST_WB
  } walk_st_e;
endpackage

// File: rtl/txring_regs.sv
module txring_regs
  import txring_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic [AW-1:0] base_o,
  output logic          base_ld_o,
  output logic          poll_o,
  input  logic          stop_i,
  input  logic          cmpl_set_i,
  output logic          irq_o
);
  logic [AW-1:0] base_q, base_d;
  logic          ld_q, ld_d;
  logic          poll_q, poll_d;
  logic          flag_q, flag_d;
  logic          ien_q, ien_d;
  logic          poll_wr1;
  logic          unused_wbits;

  assign poll_wr1     = we_i && (addr_i == RA_POLL) && wdata_i[0];
  assign unused_wbits = ^wdata_i[3:1];

  always_comb begin
    base_d = base_q;
    ld_d   = 1'b0;
    poll_d = poll_q;
    flag_d = flag_q;
    ien_d  = ien_q;
    if (we_i && (addr_i == RA_BASE)) begin
      base_d = {wdata_i[AW-1:4], 4'b0000};
      ld_d   = 1'b1;
    end
    if (stop_i)   poll_d = 1'b0;
    if (poll_wr1) poll_d = 1'b1;
    if (we_i && (addr_i == RA_STAT) && wdata_i[0]) flag_d = 1'b0;
    if (cmpl_set_i) flag_d = 1'b1;
    if (we_i && (addr_i == RA_IEN)) ien_d = wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ld_q   <= 1'b0;
      poll_q <= 1'b0;
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      ld_q   <= ld_d;
      poll_q <= poll_d;
      flag_q <= flag_d;
      ien_q  <= ien_d;
    end
  end

  always_comb begin
    unique case (addr_i)
      RA_BASE: rdata_o = 32'(base_q);
      RA_POLL: rdata_o = {31'd0, poll_q};
      RA_STAT: rdata_o = {31'd0, flag_q};
      default: rdata_o = {31'd0, ien_q};
    endcase
  end

  assign base_o    = base_q;
  assign base_ld_o = ld_q;
  assign poll_o    = poll_q;
  assign irq_o     = flag_q & ien_q;

  // R8: a stop from the walker drops the poll bit unless software re-arms it
  p_stop_clears_poll_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !poll_wr1 |=> !poll_q);
  // R10: the completion flag only rises after a completion event
  p_flag_source_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(cmpl_set_i));
endmodule

// File: rtl/txring_fbuf.sv
module txring_fbuf #(
  parameter int unsigned MAXB = 64,
  parameter int unsigned LENW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [31:0]     wr_word_i,
  input  logic [LENW+1:0] wr_pos_i,
  input  logic [1:0]      off_i,
  input  logic [LENW-1:0] len_i,
  input  logic            start_i,
  output logic            tvalid_o,
  input  logic            tready_i,
  output logic [7:0]      tdata_o,
  output logic            tlast_o,
  output logic            sent_o
);
  localparam int unsigned BW = (MAXB > 1) ? $clog2(MAXB) : 1;
  localparam int unsigned XW = LENW + 3;

  logic [7:0]    store_q [MAXB];
  logic [3:0]    lane_ok;
  logic [BW-1:0] lane_idx [4];
  logic [LENW-1:0] rd_q, rd_d;
  logic            act_q, act_d;
  logic            at_end;

  // one lane per byte of the fetched word
  for (genvar b = 0; b < 4; b++) begin : g_lane
    logic [XW-1:0] absb, rel;
    assign absb = XW'(wr_pos_i) + XW'(b);
    assign rel  = absb - XW'(off_i);
    assign lane_ok[b]  = (absb >= XW'(off_i)) && (rel < XW'(len_i)) && (rel < XW'(MAXB));
    assign lane_idx[b] = rel[BW-1:0];
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int b = 0; b < 4; b++) begin
        if (lane_ok[b]) store_q[lane_idx[b]] <= wr_word_i[8*b +: 8];
      end
    end
  end

  assign at_end = (rd_q == len_i - LENW'(1));

  always_comb begin
    act_d  = act_q;
    rd_d   = rd_q;
    sent_o = 1'b0;
    if (start_i) begin
      act_d = 1'b1;
      rd_d  = '0;
    end else if (act_q && tready_i) begin
      if (at_end) begin
        act_d  = 1'b0;
        sent_o = 1'b1;
      end else begin
        rd_d = rd_q + LENW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      act_q <= act_d;
      rd_q  <= rd_d;
    end
  end

  assign tvalid_o = act_q;
  assign tdata_o  = store_q[rd_q[BW-1:0]];
  assign tlast_o  = act_q && at_end;

  // R5: an offered byte is held until it is taken
  p_hold_offer_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tvalid_o && !tready_i |=> tvalid_o && $stable(tdata_o) && $stable(tlast_o));
endmodule

// File: rtl/txring_fetch.sv
module txring_fetch
  import txring_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned MAXB = 64,
  parameter int unsigned LENW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            poll_i,
  input  logic [AW-1:0]   base_i,
  input  logic            base_ld_i,
  output logic            stop_o,
  output logic            cmpl_set_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [31:0]     mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [31:0]     mem_rdata_i,
  output logic            bw_en_o,
  output logic [31:0]     bw_word_o,
  output logic [LENW+1:0] bw_pos_o,
  output logic [1:0]      off_o,
  output logic [LENW-1:0] len_o,
  output logic            start_o,
  input  logic            sent_i
);
  localparam int unsigned XW = LENW + 3;
  localparam int unsigned DSTRIDE = 16;

  walk_st_e        st_q, st_d;
  logic [AW-1:0]   ptr_q, ptr_d, bad_q, bad_d;
  logic [31:0]     w0_q, w0_d;
  logic [LENW-1:0] len_q, len_d;
  logic [LENW+1:0] pos_q, pos_d;
  logic [XW-1:0]   end_pos, pos_nx;
  logic            frame_ok;
  logic            unused_lenlo;

  assign unused_lenlo = ^mem_rdata_i[15:0];
  assign end_pos  = XW'(len_q) + XW'(bad_q[1:0]);
  assign pos_nx   = XW'(pos_q) + XW'(4);
  assign frame_ok = w0_q[BIT_SOF] && w0_q[BIT_EOF] && (len_q != '0)
                    && ((LENW+1)'(len_q) <= (LENW+1)'(MAXB));

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    bad_d  = bad_q;
    w0_d   = w0_q;
    len_d  = len_q;
    pos_d  = pos_q;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr_q;
    mem_wdata_o = w0_q & ~(32'd1 << BIT_OWN);
    stop_o      = 1'b0;
    cmpl_set_o  = 1'b0;
    bw_en_o     = 1'b0;
    start_o     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (base_ld_i)   ptr_d = base_i;
        else if (poll_i) st_d  = ST_W0;
      end
      ST_W0: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          w0_d = mem_rdata_i;
          if (!mem_rdata_i[BIT_OWN]) begin
            stop_o = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            st_d = ST_W1;
          end
        end
      end
      ST_W1: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ptr_q + AW'(4);
        if (mem_ack_i) begin
          len_d = mem_rdata_i[31:16];
          st_d  = ST_W2;
        end
      end
      ST_W2: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ptr_q + AW'(8);
        if (mem_ack_i) begin
          bad_d = mem_rdata_i[AW-1:0];
          pos_d = '0;
          st_d  = frame_ok ? ST_BUF : ST_WB;
        end
      end
      ST_BUF: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {bad_q[AW-1:2], 2'b00} + AW'(pos_q);
        if (mem_ack_i) begin
          bw_en_o = 1'b1;
          pos_d   = pos_nx[LENW+1:0];
          if (pos_nx >= end_pos) begin
            start_o = 1'b1;
            st_d    = ST_SEND;
          end
        end
      end
      ST_SEND: begin
        if (sent_i) st_d = ST_WB;
      end
      ST_WB: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_ack_i) begin
          cmpl_set_o = w0_q[BIT_CMPL];
          ptr_d      = w0_q[BIT_WRAP] ? base_i : ptr_q + AW'(DSTRIDE);
          st_d       = ST_W0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ptr_q <= '0;
      bad_q <= '0;
      w0_q  <= '0;
      len_q <= '0;
      pos_q <= '0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      bad_q <= bad_d;
      w0_q  <= w0_d;
      len_q <= len_d;
      pos_q <= pos_d;
    end
  end

  assign bw_word_o = mem_rdata_i;
  assign bw_pos_o  = pos_q;
  assign off_o     = bad_q[1:0];
  assign len_o     = len_q;

  // R2: an open request keeps its address and direction until acknowledged
  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
endmodule

// File: rtl/txring_dma.sv
module txring_dma #(
  parameter int unsigned AW   = 32,
  parameter int unsigned MAXB = 64,
  parameter int unsigned LENW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          tx_tvalid_o,
  input  logic          tx_tready_i,
  output logic [7:0]    tx_tdata_o,
  output logic          tx_tlast_o,
  output logic          irq_o
);
  logic [1:0]      rsync_q;
  logic            rst_n;
  logic [AW-1:0]   base;
  logic            base_ld, poll, stop, cmpl_set;
  logic            bw_en, start, sent;
  logic [31:0]     bw_word;
  logic [LENW+1:0] bw_pos;
  logic [1:0]      off;
  logic [LENW-1:0] len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  txring_regs #(.AW(AW)) i_regs (
    .clk_i(clk_i), .rst_ni(rst_n),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .base_o(base), .base_ld_o(base_ld), .poll_o(poll),
    .stop_i(stop), .cmpl_set_i(cmpl_set), .irq_o(irq_o)
  );

  txring_fetch #(.AW(AW), .MAXB(MAXB), .LENW(LENW)) i_fetch (
    .clk_i(clk_i), .rst_ni(rst_n),
    .poll_i(poll), .base_i(base), .base_ld_i(base_ld),
    .stop_o(stop), .cmpl_set_o(cmpl_set),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .bw_en_o(bw_en), .bw_word_o(bw_word), .bw_pos_o(bw_pos), .off_o(off), .len_o(len),
    .start_o(start), .sent_i(sent)
  );

  txring_fbuf #(.MAXB(MAXB), .LENW(LENW)) i_fbuf (
    .clk_i(clk_i), .rst_ni(rst_n),
    .wr_en_i(bw_en), .wr_word_i(bw_word), .wr_pos_i(bw_pos), .off_i(off), .len_i(len),
    .start_i(start), .tvalid_o(tx_tvalid_o), .tready_i(tx_tready_i),
    .tdata_o(tx_tdata_o), .tlast_o(tx_tlast_o), .sent_o(sent)
  );

  // R4: streaming and memory traffic never overlap
  p_no_fetch_while_stream_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    tx_tvalid_o |-> !mem_req_o);
endmodule

// File: tb/test_txring_dma.sv
module test_txring_dma;
  localparam int unsigned MAXB = 64;
  localparam logic [31:0] F_OWN  = 32'h8000_0000;
  localparam logic [31:0] F_WRAP = 32'h4000_0000;
  localparam logic [31:0] F_SOF  = 32'h2000_0000;
  localparam logic [31:0] F_EOF  = 32'h1000_0000;
  localparam logic [31:0] F_CMPL = 32'h0100_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tvalid, tready, tlast, irq;
  logic [7:0]  tdata;

  logic [31:0] mem [512];
  logic        bk_we;
  logic [8:0]  bk_addr;
  logic [31:0] bk_data;

  logic [7:0]  got [4096];
  logic        islast [4096];
  int          cnt = 0;
  int          overlap = 0;
  logic [7:0]  lfsr;
  logic        rdy_mode;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  txring_dma i_txring_dma (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .tx_tvalid_o(tvalid), .tx_tready_i(tready), .tx_tdata_o(tdata), .tx_tlast_o(tlast),
    .irq_o(irq)
  );

  // memory responder: one access per two cycles, ack with data
  initial mem_ack = 1'b0;
  always @(posedge clk) begin
    if (bk_we) mem[bk_addr] <= bk_data;
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[10:2]];
      if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // ready pattern update, then record the handshake due at the next edge
  initial begin lfsr = 8'h5A; tready = 1'b0; end
  always @(negedge clk) begin
    lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tready = rdy_mode ? lfsr[0] : 1'b1;
    if (tvalid && mem_req) overlap++;
    if (tvalid && tready) begin
      got[cnt]    = tdata;
      islast[cnt] = tlast;
      cnt++;
    end
  end

  function automatic logic [7:0] byte_at(int unsigned a);
    return 8'(a * 37 + 11);
  endfunction

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic poke(int unsigned word, logic [31:0] d);
    @(negedge clk);
    bk_we = 1'b1; bk_addr = 9'(word); bk_data = d;
    @(negedge clk);
    bk_we = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_desc(int unsigned da, logic [31:0] w0, int unsigned len, int unsigned ba);
    poke(da / 4,     w0);
    poke(da / 4 + 1, {16'(len), 16'hBEEF});
    poke(da / 4 + 2, 32'(ba));
    poke(da / 4 + 3, 32'hDEAD_0000);
  endtask

  task automatic run_ring(string tag);
    logic [31:0] v;
    bit done;
    done = 1'b0;
    wr(2'd1, 32'd1);
    for (int i = 0; i < 4000; i++) begin
      rd(2'd1, v);
      if (v[0] == 1'b0) begin done = 1'b1; break; end
    end
    chk(done, {tag, " walk stops and clears poll"}, longint'(done), 1);
    repeat (2) @(negedge clk);
  endtask

  // compare captured bytes from index s against buffer at ba
  task automatic chk_bytes(int s, int unsigned ba, int unsigned len, string tag);
    int bad;
    logic [7:0] a, e;
    bad = -1; a = 0; e = 0;
    for (int k = 0; k < int'(len); k++) begin
      if (bad < 0 && got[s + k] !== byte_at(ba + k)) begin
        bad = k; a = got[s + k]; e = byte_at(ba + k);
      end
    end
    chk(bad < 0, {tag, " byte order and lanes"}, longint'(a), longint'(e));
    bad = 0;
    for (int k = 0; k < int'(len) - 1; k++) if (islast[s + k]) bad++;
    chk(bad == 0 && islast[s + int'(len) - 1] === 1'b1, {tag, " tlast only on final byte"},
        longint'(bad), 0);
  endtask

  initial begin
    logic [31:0] v;
    int s;
    int unsigned len;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    bk_we = 1'b0; bk_addr = '0; bk_data = '0; rdy_mode = 1'b0;
    repeat (4) @(negedge clk);
    // R1 outputs held low in reset
    chk(!tvalid && !mem_req && !irq, "R1 outputs low in reset", {tvalid, mem_req, irq}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 0, "R1 register reset value", v, 0);
    end
    chk(!tvalid && !mem_req && !irq, "R1 outputs low after reset", {tvalid, mem_req, irq}, 0);

    // buffer region 0x200..0x7FF holds byte_at(address)
    for (int w = 128; w < 512; w++)
      poke(w, {byte_at(4*w+3), byte_at(4*w+2), byte_at(4*w+1), byte_at(4*w)});

    wr(2'd0, 32'h0);
    wr(2'd3, 32'd1);

    // sweep: every alignment, short lengths and the maximum
    for (int off = 0; off < 4; off++) begin
      for (int li = 0; li < 11; li++) begin
        len = (li < 9) ? li + 1 : ((li == 9) ? MAXB - 1 : MAXB);
        set_desc(0, F_OWN | F_WRAP | F_SOF | F_EOF | F_CMPL, len, 32'h200 + off);
        rdy_mode = li[0];
        s = cnt;
        run_ring("R8 sweep");
        chk(cnt - s == int'(len), "R2 R3 byte count from word1 upper half", cnt - s, len);
        chk_bytes(s, 32'h200 + off, len, "R3 R5");
        chk(mem[0] == (F_WRAP | F_SOF | F_EOF | F_CMPL), "R6 write-back clears own only",
            mem[0], F_WRAP | F_SOF | F_EOF | F_CMPL);
        rd(2'd2, v);
        chk(v[0] == 1'b1, "R10 completion flag set", v[0], 1);
        chk(irq == 1'b1, "R11 irq with flag and enable", irq, 1);
        wr(2'd2, 32'd1);
        rd(2'd2, v);
        chk(v[0] == 1'b0 && irq == 1'b0, "R10 R11 write-one clear", v[0], 0);
      end
    end

    // three-entry ring at 0x100, wrap on the third, fourth still owned
    wr(2'd0, 32'h100);
    set_desc(32'h100, F_OWN | F_SOF | F_EOF, 5, 32'h300);
    set_desc(32'h110, F_OWN | F_SOF | F_EOF, 3, 32'h342);
    set_desc(32'h120, F_OWN | F_WRAP | F_SOF | F_EOF, 7, 32'h381);
    set_desc(32'h130, F_OWN | F_SOF | F_EOF, 4, 32'h300);
    rdy_mode = 1'b1;
    s = cnt;
    run_ring("R12 ring");
    chk(cnt - s == 15, "R7 R12 three frames then wrap", cnt - s, 15);
    chk_bytes(s,     32'h300, 5, "R7 frame A");
    chk_bytes(s + 5, 32'h342, 3, "R7 frame B");
    chk_bytes(s + 8, 32'h381, 7, "R7 frame C");
    chk(mem[32'h130/4] == (F_OWN | F_SOF | F_EOF), "R7 entry past wrap untouched",
        mem[32'h130/4], F_OWN | F_SOF | F_EOF);
    chk(mem[32'h100/4] == (F_SOF | F_EOF) && mem[32'h110/4] == (F_SOF | F_EOF),
        "R6 ring entries handed back", mem[32'h100/4], F_SOF | F_EOF);
    rd(2'd2, v);
    chk(v[0] == 1'b0, "R10 no flag without completion request", v[0], 0);

    // skipped descriptors: partial frame, zero length, too long
    wr(2'd3, 32'd0);
    set_desc(32'h100, F_OWN | F_SOF, 4, 32'h300);
    set_desc(32'h110, F_OWN | F_SOF | F_EOF, 0, 32'h300);
    set_desc(32'h120, F_OWN | F_WRAP | F_SOF | F_EOF | F_CMPL, MAXB + 1, 32'h300);
    s = cnt;
    run_ring("R9 skip");
    chk(cnt - s == 0, "R9 skipped descriptors send nothing", cnt - s, 0);
    chk(mem[32'h100/4] == F_SOF && mem[32'h110/4] == (F_SOF | F_EOF)
        && mem[32'h120/4] == (F_WRAP | F_SOF | F_EOF | F_CMPL),
        "R9 skipped descriptors handed back", mem[32'h120/4], F_WRAP | F_SOF | F_EOF | F_CMPL);
    rd(2'd2, v);
    chk(v[0] == 1'b1, "R10 flag from skipped descriptor", v[0], 1);
    chk(irq == 1'b0, "R11 irq masked when disabled", irq, 0);
    wr(2'd3, 32'd1);
    @(negedge clk);
    chk(irq == 1'b1, "R11 irq after enable", irq, 1);
    wr(2'd2, 32'd0);
    rd(2'd2, v);
    chk(v[0] == 1'b1, "R10 writing zero keeps flag", v[0], 1);
    wr(2'd2, 32'd1);

    // poll bit: writing zero does nothing
    set_desc(32'h100, F_OWN | F_WRAP | F_SOF | F_EOF, 2, 32'h300);
    s = cnt;
    wr(2'd1, 32'd0);
    repeat (40) @(negedge clk);
    rd(2'd1, v);
    chk(v[0] == 1'b0 && cnt == s, "R13 zero write starts nothing", cnt - s, 0);
    chk(mem[32'h100/4][31] == 1'b1, "R13 descriptor still owned", mem[32'h100/4][31], 1);
    run_ring("R13 start");
    chk(cnt - s == 2, "R13 one write starts walk", cnt - s, 2);

    // owned-bit clear at the fetch position: stop at once
    s = cnt;
    run_ring("R8 idle ring");
    chk(cnt - s == 0, "R8 unowned descriptor not sent", cnt - s, 0);
    chk(mem[32'h100/4] == (F_WRAP | F_SOF | F_EOF), "R8 unowned descriptor not written",
        mem[32'h100/4], F_WRAP | F_SOF | F_EOF);

    // base move while stopped
    set_desc(32'h100, F_OWN | F_WRAP | F_SOF | F_EOF, 6, 32'h300);
    set_desc(0, F_OWN | F_WRAP | F_SOF | F_EOF, 4, 32'h203);
    wr(2'd0, 32'h0000_0007);
    rd(2'd0, v);
    chk(v == 0, "R12 base low bits forced to zero", v, 0);
    s = cnt;
    run_ring("R12 rebase");
    chk(cnt - s == 4, "R12 walk resumes at new base", cnt - s, 4);
    chk_bytes(s, 32'h203, 4, "R12 rebase frame");

    chk(overlap == 0, "R4 no stream byte during memory access", overlap, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule